// File: doc/BRIEF.md
# Replica-Locked Body-Bias Controller

This controller closes a loop around a critical-path replica oscillator. The oscillator runs on the same silicon as the logic it stands for. The controller counts rising edges of the replica over a fixed window of reference-clock cycles. It compares that count with a target chosen by the requested performance level, and it moves a signed body-bias code by one step per window. A replica that runs too slowly pushes the code toward forward bias, which lowers the threshold. A replica that runs too fast pushes it toward reverse bias, which raises the threshold and cuts leakage.

The performance demand also sets a clock-divider select output. At the top demand level the controller selects full speed and outputs the zero (no-bias) code, which gives the lowest threshold without forcing the devices forward. At lower levels it selects a slower clock and lets the loop settle at a more reverse code. The analog bias generator and the replica circuit are outside the block. Both appear here only as digital signals.

Top module: `bias_loop_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `bias` is 0 and `clk_sel` is 3 (full speed), until the first window boundary.
- R2: A window lasts 64 `clk` cycles. The first window ends on the 64th rising edge after reset release. `bias` changes only at a window boundary, and by at most one code per window unless it is forced to 0.
- R3: At a non-peak level, a window count below target minus 1 raises `bias` by one (toward forward bias and a lower threshold).
- R4: At a non-peak level, a window count above target plus 1 lowers `bias` by one (toward reverse bias and a higher threshold).
- R5: A window count equal to target minus 1, target, or target plus 1 leaves `bias` unchanged.
- R6: The target for demand level L (0, 1 or 2) is 6 + 4·L edges per window.
- R7: Demand level 3 is peak. If `demand` is 3 at a boundary, `bias` becomes 0 and `clk_sel` becomes 3. A window that ran at peak leaves `bias` at 0 whatever the count.
- R8: `demand` is sampled only at a window boundary, and `clk_sel` then shows the sampled level (0 is the slowest setting). A window is judged against the level that was in effect while it ran, not against the level sampled at its end.
- R9: `bias` is a 4-bit two's-complement code: 0 means no bias, positive means forward bias, negative means reverse bias. It saturates at +7 and at −8 and never wraps.
- R10: `rep_osc` is asynchronous and passes through a two-flop synchronizer. Each rising edge whose high and low phases each last at least two `clk` cycles counts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; defines the measurement window |
| rst_n | input | 1 | Active-low asynchronous reset |
| demand | input | 2 | Requested performance level, 3 = peak |
| rep_osc | input | 1 | Critical-path replica oscillator output |
| clk_sel | output | 2 | Clock-divider select, 3 = full speed |
| bias | output | 4 | Signed body-bias code, positive = forward |

## Verification
The bench places exact edge counts at target−2, target−1, target+1 and target+2. A deadband that is off by one, or is missing, then shows up as a step where the code should hold, or a hold where it should step. It drives the code into both limits for extra windows, so a code that wraps instead of saturating jumps to the opposite extreme. It changes the demand level inside a window whose count means opposite directions under the old and new targets, so a design that judges the window against the newly sampled level steps the wrong way. It also lets a peak-level window with no replica edges pass, so a design that runs the loop at peak leaves a non-zero code.

// File: rtl/bias_loop_ctrl.sv
module bias_loop_ctrl #(
  parameter int BW       = 4,
  parameter int DW       = 2,
  parameter int WIN_LOG2 = 6,
  parameter int TGT_BASE = 6,
  parameter int TGT_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        demand,
  input  logic                 rep_osc,
  output logic [DW-1:0]        clk_sel,
  output logic signed [BW-1:0] bias
);
  localparam int CW = WIN_LOG2 + 1;
  localparam int TW = CW + DW + 4;
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic signed [BW-1:0] BMAX = {1'b0, {(BW-1){1'b1}}};
  localparam logic signed [BW-1:0] BMIN = {1'b1, {(BW-1){1'b0}}};

  logic [2:0]          rsync;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [CW-1:0]       edge_cnt;
  logic signed [BW-1:0] bias_nxt;

  wire          rep_rise = rsync[1] & ~rsync[2];
  wire          win_end  = &win_cnt;
  wire [CW-1:0] total    = edge_cnt + CW'(rep_rise);
  wire [TW-1:0] target   = TW'(TGT_BASE) + TW'(TGT_STEP) * TW'(clk_sel);
  wire          slow     = (TW'(total) + TW'(1)) < target;
  wire          fast     = TW'(total) > (target + TW'(1));

  always_comb begin
    bias_nxt = bias;
    if (demand == DMAX || clk_sel == DMAX)
      bias_nxt = '0;
    else if (slow && bias != BMAX)
      bias_nxt = bias + BW'(1);
    else if (fast && bias != BMIN)
      bias_nxt = bias - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync    <= '0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      clk_sel  <= DMAX;
      bias     <= '0;
    end else begin
      rsync   <= {rsync[1:0], rep_osc};
      win_cnt <= win_cnt + WIN_LOG2'(1);
      if (win_end) begin
        edge_cnt <= '0;
        clk_sel  <= demand;
        bias     <= bias_nxt;
      end else begin
        edge_cnt <= total;
      end
    end
  end
endmodule

// File: rtl/bias_loop_chk.sv
module bias_loop_chk #(
  parameter int BW       = 4,
  parameter int DW       = 2,
  parameter int WIN_LOG2 = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WIN_LOG2-1:0]  win_cnt,
  input logic [DW-1:0]        clk_sel,
  input logic signed [BW-1:0] bias
);
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic signed [BW-1:0] BMAX = {1'b0, {(BW-1){1'b1}}};
  localparam logic signed [BW-1:0] BMIN = {1'b1, {(BW-1){1'b0}}};

  AST_BIAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(&win_cnt) |=> $stable(bias)); // R2
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bias == $past(bias)) || (bias == $past(bias) + BW'(1)) ||
             (bias == $past(bias) - BW'(1)) || (bias == '0)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(&win_cnt) |=> $stable(clk_sel)); // R8
  AST_PEAK_NOBIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == DMAX) |-> (bias == '0)); // R7
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bias == BMAX) |=> (bias != BMIN)); // R9
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bias == BMIN) |=> (bias != BMAX)); // R9
endmodule

bind bias_loop_ctrl bias_loop_chk #(.BW(BW), .DW(DW), .WIN_LOG2(WIN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_cnt(win_cnt), .clk_sel(clk_sel), .bias(bias)
);

// File: tb/test_bias_loop_ctrl.sv
`timescale 1ns/1ps
module test_bias_loop_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        demand = 2'd3;
  logic              rep_osc = 1'b0;
  logic [1:0]        clk_sel;
  logic signed [3:0] bias;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bias_loop_ctrl i_bias_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .demand(demand), .rep_osc(rep_osc),
    .clk_sel(clk_sel), .bias(bias)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one window: n replica pulses (2 high, 2 low), then outputs checked after the boundary
  task automatic run_win(input int n, input int dem, input int eb, input int es, input string req);
    logic signed [3:0] b0 = bias;
    logic [1:0]        s0 = clk_sel;
    demand = 2'(dem);
    for (int k = 0; k < 64; k++) begin
      rep_osc = (k >= 4) && (k < 4 + 4 * n) && (((k - 4) % 4) < 2);
      if (k == 32) begin
        check(bias == b0, "R2", int'(bias), int'(b0));
        check(clk_sel == s0, "R8", int'(clk_sel), int'(s0));
      end
      @(negedge clk);
    end
    check(int'(bias) == eb, req, int'(bias), eb);
    check(int'(clk_sel) == es, req, int'(clk_sel), es);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(bias == 4'sd0, "R1", int'(bias), 0);
    check(clk_sel == 2'd3, "R1", int'(clk_sel), 3);
    rst_n = 1'b1;
    @(negedge clk);
    // resync: the window count started at the release edge; finish this window
    repeat (62) @(negedge clk);
    check(bias == 4'sd0, "R1", int'(bias), 0);
    check(clk_sel == 2'd3, "R1", int'(clk_sel), 3);
    @(negedge clk);
  endtask

  task automatic t_peak_idle();
    run_win(0, 3, 0, 3, "R7");
  endtask

  task automatic t_steps_low();
    run_win(0, 0, 0, 0, "R8");
    run_win(8, 0, -1, 0, "R4");
    run_win(5, 0, -1, 0, "R5");
    run_win(7, 0, -1, 0, "R5");
    run_win(4, 0, 0, 0, "R3");
    run_win(2, 0, 1, 0, "R3");
    run_win(6, 0, 1, 0, "R10");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) run_win(12, 0, (1 - (i + 1) < -8) ? -8 : 1 - (i + 1), 0, "R9");
    for (int i = 0; i < 17; i++) run_win(0, 0, (-8 + i + 1 > 7) ? 7 : -8 + i + 1, 0, "R9");
  endtask

  task automatic t_peak_force();
    run_win(0, 3, 0, 3, "R7");
  endtask

  task automatic t_levels();
    run_win(10, 1, 0, 1, "R8");
    run_win(10, 1, 0, 1, "R6");
    run_win(12, 1, -1, 1, "R6");
    run_win(8, 1, 0, 1, "R6");
    run_win(12, 1, -1, 1, "R4");
    run_win(12, 2, -2, 2, "R8");
    run_win(12, 2, -1, 2, "R6");
    run_win(9, 2, 0, 2, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_peak_idle();
    t_steps_low();
    t_saturate();
    t_peak_force();
    t_levels();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule